// File: doc/BRIEF.md
# Grouped Interrupt Arm and Acknowledge Controller

This block turns several groups of level-sensitive event signals into one active-low interrupt request whose pin can be released to high impedance. One arm bit governs the whole block. While the arm bit is low, the pin is never driven. While it is high, a group that shows an active event raises the request. That group then goes quiet, and it can raise the request again only after all of its event signals have been inactive together on the same clock.

The block reports, per group, whether that group is the one currently pulling the request low. Which events belong to which group is fixed at build time through parameters. The event vector is flattened, with group `g` occupying bits `[g*GROUP_WIDTH +: GROUP_WIDTH]`. The block has no data stream, so no valid/ready handshake applies; all of its pins are plain control and status levels.

Top module: `irqg_arm_ctrl`

## Requirements
- R1: While `arm_i` is 0, `irq_oe_o` is 0 and every bit of `pend_o` is 0, whatever the events are.
- R2: With `arm_i` at 1, a group that has at least one event bit at 1 and has not yet fired sets its `pend_o` bit in the same cycle.
- R3: A group whose `pend_o` bit was 1 on a clock edge has fired. Its `pend_o` bit is 0 in the next cycle and stays 0 for as long as any of its event bits stays at 1.
- R4: A fired group becomes able to request again only after a clock on which all of its event bits were 0. A later active event then sets its `pend_o` bit again.
- R5: A clock edge with `arm_i` at 0 clears every group's fired state. After re-arming, groups with active events request at once.
- R6: With `arm_i` at 1 and no event bit set, `irq_oe_o` is 0.
- R7: Groups are independent. A fired group does not stop another group from requesting.
- R8: `irq_oe_o` is 1 exactly when any `pend_o` bit is 1. `irq_n_o` is 0 when `irq_oe_o` is 1 and is 1 otherwise.
- R9: Active-low reset `rst_n` clears every group's fired state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm/acknowledge control bit |
| evt_i | input | NUM_GROUPS*GROUP_WIDTH | Flattened per-group event levels, active high |
| irq_n_o | output | 1 | Value for the request pin, low means request |
| irq_oe_o | output | 1 | Output enable for the request pin, 0 means high impedance |
| pend_o | output | NUM_GROUPS | Per-group flag, 1 while that group holds the request |

## Verification
The bench builds the block with three groups of four events each. This lets one group stay fired while a second group requests, and lets a partial clear inside a group (a different bit still active) be told apart from a full clear. Three groups also allow all groups to request together, and let reset and disarm be shown to release groups that were fired with their events still held.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  typedef enum logic {
    GRP_OPEN  = 1'b0,
    GRP_SPENT = 1'b1
  } grp_state_e;
endpackage

// File: rtl/irqg_group_tracker.sv
module irqg_group_tracker
  import irqg_pkg::*;
#(
  parameter int GROUP_WIDTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm_i,
  input  logic [GROUP_WIDTH-1:0] evt_i,
  output logic                   pend_o
);
  grp_state_e state_q, state_d;
  logic       any_active;

  assign any_active = |evt_i;
  // Request while armed, active and not yet spent
  assign pend_o = arm_i && any_active && (state_q == GRP_OPEN);

  always_comb begin
    state_d = state_q;
    if (!arm_i)          state_d = GRP_OPEN;
    else if (pend_o)     state_d = GRP_SPENT;
    else if (!any_active) state_d = GRP_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= GRP_OPEN;
    else        state_q <= state_d;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |=> !pend_o); // R3
  AST_DISARM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && any_active) |=> (!arm_i || pend_o || !(|evt_i))); // R5
endmodule

// File: rtl/irqg_pin_drive.sv
module irqg_pin_drive #(
  parameter int NUM_GROUPS = 3
) (
  input  logic [NUM_GROUPS-1:0] pend_i,
  output logic                  irq_n_o,
  output logic                  irq_oe_o
);
  assign irq_oe_o = |pend_i;
  assign irq_n_o  = ~irq_oe_o;
endmodule

// File: rtl/irqg_arm_ctrl.sv
module irqg_arm_ctrl #(
  parameter int NUM_GROUPS  = 3,
  parameter int GROUP_WIDTH = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              arm_i,
  input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] evt_i,
  output logic                              irq_n_o,
  output logic                              irq_oe_o,
  output logic [NUM_GROUPS-1:0]             pend_o
);
  localparam int EVT_BITS = NUM_GROUPS * GROUP_WIDTH;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irqg_group_tracker #(.GROUP_WIDTH(GROUP_WIDTH)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (arm_i),
      .evt_i  (evt_i[g*GROUP_WIDTH +: GROUP_WIDTH]),
      .pend_o (pend_o[g])
    );
  end

  irqg_pin_drive #(.NUM_GROUPS(NUM_GROUPS)) u_pin (
    .pend_i   (pend_o),
    .irq_n_o  (irq_n_o),
    .irq_oe_o (irq_oe_o)
  );

  AST_DISARM_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |-> (!irq_oe_o && pend_o == '0)); // R1
  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == {EVT_BITS{1'b0}}) |-> !irq_oe_o); // R6
  AST_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe_o == (pend_o != '0)) && (irq_n_o == !irq_oe_o)); // R8
endmodule

// File: tb/sim_irqg_arm_ctrl.sv
`timescale 1ns/1ps
module sim_irqg_arm_ctrl;
  localparam int NG = 3;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [NG*GW-1:0] evt = '0;
  logic irq_n, irq_oe;
  logic [NG-1:0] pend;

  int checks = 0;
  int fails = 0;
  int fired[NG];

  always #2 clk = ~clk;

  irqg_arm_ctrl #(.NUM_GROUPS(NG), .GROUP_WIDTH(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .evt_i(evt),
    .irq_n_o(irq_n), .irq_oe_o(irq_oe), .pend_o(pend));

  function automatic bit grp_active(int g);
    return ((evt >> (g*GW)) & 12'hF) != 0;
  endfunction

  function automatic logic [NG-1:0] model_pend();
    logic [NG-1:0] p = '0;
    for (int g = 0; g < NG; g++)
      p[g] = arm && grp_active(g) && (fired[g] == 0);
    return p;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NG*GW-1:0] e, input logic a, input logic r, input string tag);
    logic [NG-1:0] ep;
    evt = e; arm = a; rst_n = r;
    #1;
    ep = model_pend();
    chk(tag, "pend", pend, ep);
    chk(tag, "oe", irq_oe, (ep != 0));
    chk("R8", "irq_n", irq_n, !(ep != 0));
    @(posedge clk);
    for (int g = 0; g < NG; g++) begin
      if (!r || !a)              fired[g] = 0;
      else if (ep[g])            fired[g] = 1;
      else if (!grp_active(g))   fired[g] = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int g = 0; g < NG; g++) fired[g] = 0;
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    @(negedge clk);
    step(12'h000, 0, 0, "R9");
    step(12'h000, 0, 0, "R9");
    // R1: disarmed with all events active
    step(12'hFFF, 0, 1, "R1");
    step(12'hFFF, 0, 1, "R1");
    // R6: armed, no events
    step(12'h000, 1, 1, "R6");
    // R2: single group request
    step(12'h001, 1, 1, "R2");
    // R3: held event does not re-request
    step(12'h001, 1, 1, "R3");
    step(12'h001, 1, 1, "R3");
    step(12'h002, 1, 1, "R4");
    // R4: full clear then new event
    step(12'h000, 1, 1, "R4");
    step(12'h004, 1, 1, "R4");
    step(12'h004, 1, 1, "R4");
    // R7: another group requests while group 0 is spent
    step(12'h014, 1, 1, "R7");
    step(12'h014, 1, 1, "R7");
    // R5: disarm clears fired state
    step(12'h014, 0, 1, "R5");
    step(12'h014, 1, 1, "R5");
    step(12'h014, 1, 1, "R5");
    // R9: reset clears fired state
    step(12'h014, 1, 0, "R9");
    step(12'h014, 1, 1, "R9");
    step(12'h014, 1, 1, "R9");
    // R8: all groups at once after a clear
    step(12'h000, 1, 1, "R8");
    step(12'h111, 1, 1, "R8");
    step(12'h111, 1, 1, "R8");
    step(12'h100, 1, 1, "R4");
    step(12'h000, 1, 1, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule